// File: doc/BRIEF.md
# Three-Bank Interrupt Status Controller

This block gathers interrupt events into three 32-bit status banks (normal, external and error) and drives one interrupt line toward the processor. An event arrives on a 64-bit identifier. The upper 32-bit word holds a bank code and the lower 32-bit word holds a bit-mask. The command that comes with the event raises those bits, clears them or toggles them.

Each bank has its own enable register. The interrupt line is the registered OR, across all banks, of the status bits ANDed with that bank's enable. A host port gives register read access to every bank and every enable. Writing 1 bits to a status address clears those bits, so the host can acknowledge events. If an event command and a host write target the same bank in the same cycle, the command wins.

Top module: `irq_bank_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status and enable register clears to 0, and `irq_out` and `cmd_err` are 0 after that edge.
- R2: With `cmd_valid` high, `cmd_op` = 0 (raise) ORs `cmd_event[31:0]` into the bank selected by `cmd_event[63:32]`: 1 selects normal, 2 selects external, 3 selects error.
- R3: `cmd_op` = 1 (clear) removes the mask bits from the selected bank's status.
- R4: `cmd_op` = 2 (toggle) clears the mask bits when any of them is already set in the selected bank. Otherwise it sets the mask bits.
- R5: With `cmd_valid` high, a bank word other than 1, 2 or 3 leaves every bank unchanged, whatever the operation. `cmd_err` is then high for exactly the one cycle after that edge.
- R6: `cmd_op` = 3 is reserved. It changes no bank and raises no error when the bank word is legal.
- R7: A host write (`host_wr` high) to address 0, 1 or 2 (normal, external, error status) clears the status bits where `host_wdata` is 1 and leaves the other bits unchanged.
- R8: When a legal command and a host status write target the same bank at the same edge, only the command takes effect on that bank. A host write to a different bank still applies.
- R9: A host write to address 4, 5 or 6 loads the enable register of the normal, external or error bank with `host_wdata`.
- R10: `irq_out` is high in the cycle after an edge at which some bank had a status bit set whose enable bit was also set, and low otherwise.
- R11: `host_rdata` shows, without delay, the status register at addresses 0 to 2 and the enable register at addresses 4 to 6. Addresses 3 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Event command present this cycle |
| cmd_op | input | 2 | 0 raise, 1 clear, 2 toggle, 3 reserved |
| cmd_event | input | 64 | Bank code in [63:32], bit-mask in [31:0] |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| irq_out | output | 1 | Registered combined interrupt line |
| cmd_err | output | 1 | One-cycle pulse for an illegal bank code |

## Verification
Toggles are driven with sparse masks against banks that are partly filled, which separates the clear-if-any-set branch from the set branch. Illegal bank words include 0, 4 and values with high bits set, which tells a decoder that looks at every bit of the bank word from one that looks at only the low bits. Commands and host clears are aimed at the same bank and at different banks in the same cycle, which separates per-bank priority from a global lockout. Enables are varied against the status bits, which exposes a missing mask term or a missing register stage on the interrupt line.

// File: rtl/irq_bank_pkg.sv
// Package: shared constants for the three-bank interrupt status controller.
// Assumes: bank codes start at 1, and bank index = code - 1.
package irq_bank_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_BANKS = 3;
    localparam int ADDR_W    = 3;

    localparam logic [1:0] OP_RAISE  = 2'd0;
    localparam logic [1:0] OP_CLEAR  = 2'd1;
    localparam logic [1:0] OP_TOGGLE = 2'd2;
    localparam logic [1:0] OP_NOP    = 2'd3;
endpackage

// File: rtl/irq_cmd_decode.sv
// Module: splits an event identifier into a one-hot bank hit and a mask.
// Assumes: the bank word is the upper half and is legal from 1 to NUM_BANKS.
//          Every bit of the bank word takes part in the legality check.
module irq_cmd_decode #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3
) (
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [2*DATA_W-1:0]   cmd_event,
    output logic [NUM_BANKS-1:0]  bank_hit,
    output logic                  bad_code,
    output logic [DATA_W-1:0]     mask
);
    import irq_bank_pkg::*;

    logic [DATA_W-1:0] code;
    logic              legal;

    // Purpose: split the event and judge the bank word.
    always_comb begin
        code  = cmd_event[2*DATA_W-1:DATA_W];
        mask  = cmd_event[DATA_W-1:0];
        legal = (code >= DATA_W'(1)) && (code <= DATA_W'(NUM_BANKS));
    end

    // Purpose: flag an illegal bank word on any valid command.
    always_comb bad_code = cmd_valid && !legal;

    // Purpose: one hit line per bank for legal, non-reserved commands.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        always_comb bank_hit[b] = cmd_valid && (cmd_op != OP_NOP)
                                  && (code == DATA_W'(b + 1));
    end
endmodule

// File: rtl/irq_host_decode.sv
// Module: decodes host addresses into per-bank strobes and muxes read data.
// Assumes: address bit 2 selects the enable page and the low bits index a bank.
//          Indexes at or above NUM_BANKS decode to nothing and read 0.
module irq_host_decode #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 3
) (
    input  logic                        host_wr,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [NUM_BANKS*DATA_W-1:0] status_flat,
    input  logic [NUM_BANKS*DATA_W-1:0] enable_flat,
    output logic [NUM_BANKS-1:0]        st_clr,
    output logic [NUM_BANKS-1:0]        en_wr,
    output logic [DATA_W-1:0]           rdata
);
    localparam int IDX_W = ADDR_W - 1;

    logic             page_en;
    logic [IDX_W-1:0] idx;

    // Purpose: split the address into page and bank index.
    always_comb begin
        page_en = host_addr[ADDR_W-1];
        idx     = host_addr[IDX_W-1:0];
    end

    // Purpose: per-bank write strobes for the status and enable pages.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        always_comb begin
            st_clr[b] = host_wr && !page_en && (idx == IDX_W'(b));
            en_wr[b]  = host_wr &&  page_en && (idx == IDX_W'(b));
        end
    end

    // Purpose: read mux, with 0 for unmapped indexes.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx == IDX_W'(b)) begin
                rdata = page_en ? enable_flat[b*DATA_W +: DATA_W]
                                : status_flat[b*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
// Module: one status bank and its enable register.
// Assumes: a command hit takes priority over a host write-one-to-clear.
//          The reserved operation never reaches this module as a hit.
module irq_status_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_hit,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic              host_clr,
    input  logic              host_en_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] enable_q
);
    import irq_bank_pkg::*;

    logic [DATA_W-1:0] cmd_next;
    logic              any_set;

    // Purpose: compute the status a command would leave behind.
    always_comb begin
        any_set = |(status_q & cmd_mask);
        unique case (cmd_op)
            OP_RAISE:  cmd_next = status_q | cmd_mask;
            OP_CLEAR:  cmd_next = status_q & ~cmd_mask;
            OP_TOGGLE: cmd_next = any_set ? (status_q & ~cmd_mask)
                                          : (status_q | cmd_mask);
            default:   cmd_next = status_q;
        endcase
    end

    // Purpose: status register with command priority over host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (cmd_hit) begin
            status_q <= cmd_next;
        end else if (host_clr) begin
            status_q <= status_q & ~host_wdata;
        end
    end

    // Purpose: enable register loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (host_en_wr) begin
            enable_q <= host_wdata;
        end
    end
endmodule

// File: rtl/irq_line_reduce.sv
// Module: ANDs each bank with its enable, ORs across banks and registers the result.
// Assumes: the flat vectors hold bank b at bits [b*DATA_W +: DATA_W].
module irq_line_reduce #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*DATA_W-1:0] status_flat,
    input  logic [NUM_BANKS*DATA_W-1:0] enable_flat,
    output logic                        irq_q
);
    logic [NUM_BANKS-1:0] bank_pend;

    // Purpose: per-bank pending flag.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
        always_comb bank_pend[b] = |(status_flat[b*DATA_W +: DATA_W]
                                    & enable_flat[b*DATA_W +: DATA_W]);
    end

    // Purpose: register the combined line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |bank_pend;
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
// Module: top of the three-bank interrupt status controller.
// Assumes: host accesses and event commands share one clock.
//          host_rdata is combinational from host_addr.
module irq_bank_ctrl #(
    parameter int DATA_W    = irq_bank_pkg::DATA_W,
    parameter int NUM_BANKS = irq_bank_pkg::NUM_BANKS,
    parameter int ADDR_W    = irq_bank_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [2*DATA_W-1:0] cmd_event,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                irq_out,
    output logic                cmd_err
);
    localparam int FLAT_W = NUM_BANKS * DATA_W;

    logic [NUM_BANKS-1:0] bank_hit;
    logic                 bad_code;
    logic [DATA_W-1:0]    mask;
    logic [NUM_BANKS-1:0] st_clr;
    logic [NUM_BANKS-1:0] en_wr;
    logic [FLAT_W-1:0]    status_flat;
    logic [FLAT_W-1:0]    enable_flat;

    irq_cmd_decode #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_cmd (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_event (cmd_event),
        .bank_hit  (bank_hit),
        .bad_code  (bad_code),
        .mask      (mask)
    );

    irq_host_decode #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_host (
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .status_flat (status_flat),
        .enable_flat (enable_flat),
        .st_clr      (st_clr),
        .en_wr       (en_wr),
        .rdata       (host_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_status_bank #(.DATA_W(DATA_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_hit    (bank_hit[b]),
            .cmd_op     (cmd_op),
            .cmd_mask   (mask),
            .host_clr   (st_clr[b]),
            .host_en_wr (en_wr[b]),
            .host_wdata (host_wdata),
            .status_q   (status_flat[b*DATA_W +: DATA_W]),
            .enable_q   (enable_flat[b*DATA_W +: DATA_W])
        );
    end

    irq_line_reduce #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_flat (status_flat),
        .enable_flat (enable_flat),
        .irq_q       (irq_out)
    );

    // Purpose: one-cycle error pulse for an illegal bank word.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= bad_code;
    end
endmodule

// File: rtl/irq_bank_chk.sv
// Module: property checker bound to irq_bank_ctrl.
// Assumes: the bank word is legal from 1 to NUM_BANKS, and bank index = code - 1.
module irq_bank_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic [1:0]                  cmd_op,
    input logic [2*DATA_W-1:0]         cmd_event,
    input logic                        host_wr,
    input logic                        irq_out,
    input logic                        cmd_err,
    input logic [NUM_BANKS*DATA_W-1:0] status_flat,
    input logic [NUM_BANKS*DATA_W-1:0] enable_flat
);
    logic              past_valid = 1'b0;
    logic [DATA_W-1:0] code;
    logic              legal;
    int                idx;
    int                idx_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sel_now;

    // Purpose: decode the incoming event on its own.
    always_comb begin
        code  = cmd_event[2*DATA_W-1:DATA_W];
        legal = (code >= DATA_W'(1)) && (code <= DATA_W'(NUM_BANKS));
        idx   = legal ? int'(code) - 1 : 0;
    end

    // Purpose: remember the last target bank and mask.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
        idx_q      <= idx;
        mask_q     <= cmd_event[DATA_W-1:0];
    end

    // Purpose: the bank the previous command addressed, as it is now.
    always_comb sel_now = status_flat[idx_q*DATA_W +: DATA_W];

    a_r1_reset_state: assert property (@(posedge clk)
        (past_valid && $past(!rst_n)) |-> (!irq_out && !cmd_err && status_flat == '0 && enable_flat == '0));

    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && legal && cmd_op == 2'd0) |=> ((sel_now & mask_q) == mask_q));

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && legal && cmd_op == 2'd1) |=> ((sel_now & mask_q) == '0));

    a_r5_bad_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !legal && !host_wr) |=> $stable(status_flat));

    a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !legal) |=> cmd_err);

    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && cmd_err) |-> $past(cmd_valid && !legal));

    a_r6_nop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && legal && cmd_op == 2'd3 && !host_wr) |=> ($stable(status_flat) && !cmd_err));

    a_r10_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n)) |-> (irq_out == $past(|(status_flat & enable_flat))));
endmodule

bind irq_bank_ctrl irq_bank_chk #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_event   (cmd_event),
    .host_wr     (host_wr),
    .irq_out     (irq_out),
    .cmd_err     (cmd_err),
    .status_flat (status_flat),
    .enable_flat (enable_flat)
);

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_event = '0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq_out;
    logic        cmd_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] m_st [3];
    logic [31:0] m_en [3];
    logic        m_irq = 1'b0;
    logic        m_err = 1'b0;

    irq_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_event(cmd_event), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_out(irq_out), .cmd_err(cmd_err)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Reference update for one clock edge, computed from the requirements.
    task automatic model_edge();
        logic [31:0] code;
        logic        legal;
        int          hit;
        logic [31:0] msk;
        m_irq = 1'b0;
        for (int b = 0; b < 3; b++) m_irq = m_irq | (|(m_st[b] & m_en[b]));
        if (!rst_n) begin
            for (int b = 0; b < 3; b++) begin m_st[b] = '0; m_en[b] = '0; end
            m_irq = 1'b0; m_err = 1'b0;
            return;
        end
        code  = cmd_event[63:32];
        msk   = cmd_event[31:0];
        legal = (code >= 1) && (code <= 3);
        m_err = cmd_valid && !legal;
        hit   = (cmd_valid && legal && cmd_op != 2'd3) ? int'(code) - 1 : -1;
        for (int b = 0; b < 3; b++) begin
            if (b == hit) begin
                case (cmd_op)
                    2'd0: m_st[b] = m_st[b] | msk;
                    2'd1: m_st[b] = m_st[b] & ~msk;
                    default: m_st[b] = (|(m_st[b] & msk)) ? (m_st[b] & ~msk) : (m_st[b] | msk);
                endcase
            end else if (host_wr && !host_addr[2] && int'(host_addr[1:0]) == b) begin
                m_st[b] = m_st[b] & ~host_wdata;
            end
        end
        if (host_wr && host_addr[2] && host_addr[1:0] != 2'd3)
            m_en[host_addr[1:0]] = host_wdata;
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        if (a[1:0] == 2'd3) return '0;
        return a[2] ? m_en[a[1:0]] : m_st[a[1:0]];
    endfunction

    // One clock: edge, model update, then compare outputs and all registers.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmd_valid = 1'b0; host_wr = 1'b0;
        check({req, " R10 irq"}, {31'b0, irq_out}, {31'b0, m_irq});
        check({req, " R5 err"}, {31'b0, cmd_err}, {31'b0, m_err});
        for (int a = 0; a < 8; a++) begin
            host_addr = 3'(a);
            #1;
            check({req, " R11 read"}, host_rdata, exp_read(3'(a)));
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] bank, input logic [31:0] msk);
        cmd_valid = 1'b1; cmd_op = op; cmd_event = {bank, msk};
    endtask

    task automatic hwr(input logic [2:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 3; b++) begin m_st[b] = '0; m_en[b] = '0; end
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq_out}, 32'd0);

        // Directed corner cases.
        cmd(2'd0, 32'd1, 32'h0000_00F0); step("R2 raise normal");
        cmd(2'd0, 32'd2, 32'h8000_0001); step("R2 raise external");
        cmd(2'd0, 32'd3, 32'h0001_0000); step("R2 raise error");
        cmd(2'd1, 32'd1, 32'h0000_0030); step("R3 clear normal");
        cmd(2'd2, 32'd2, 32'h0000_0003); step("R4 toggle partly set clears");
        cmd(2'd2, 32'd2, 32'h0000_0006); step("R4 toggle unset raises");
        cmd(2'd0, 32'd0, 32'hFFFF_FFFF); step("R5 code 0");
        cmd(2'd1, 32'd4, 32'hFFFF_FFFF); step("R5 code 4");
        cmd(2'd0, 32'h1000_0001, 32'h0000_0F00); step("R5 high bits");
        cmd(2'd3, 32'd1, 32'hFFFF_FFFF); step("R6 reserved op");
        hwr(3'd1, 32'h8000_0000); step("R7 host clear external");
        cmd(2'd0, 32'd1, 32'h0000_0001); hwr(3'd0, 32'hFFFF_FFFF); step("R8 same bank command wins");
        cmd(2'd0, 32'd3, 32'h0000_0002); hwr(3'd1, 32'hFFFF_FFFF); step("R8 other bank host applies");
        hwr(3'd6, 32'h0000_0002); step("R9 enable error");
        step("R10 irq follows");
        hwr(3'd6, 32'h0); step("R10 irq drop");
        step("R10 irq low");
        hwr(3'd7, 32'hFFFF_FFFF); step("R11 unmapped write");

        // Random mix with a fixed seed.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] bk;
            logic [31:0] mk;
            int r;
            r  = int'($urandom_range(0, 9));
            bk = (r < 8) ? 32'($urandom_range(1, 3)) : (r == 8 ? 32'd0 : $urandom);
            r  = int'($urandom_range(0, 2));
            mk = (r == 0) ? $urandom : (32'd1 << $urandom_range(0, 7)) | (32'd1 << $urandom_range(0, 7));
            if ($urandom_range(0, 3) != 0) cmd(2'($urandom_range(0, 3)), bk, mk);
            if ($urandom_range(0, 2) == 0) hwr(3'($urandom_range(0, 7)), $urandom & $urandom);
            step("R2 R3 R4 R7 R8 R9 random");
        end

        rst_n = 1'b0; step("R1 second reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule